// File: doc/BRIEF.md
# I2S Controller Serial Transmitter

This block drives an outgoing I2S link as the clock source. It produces the bit clock and the word-select line itself and shifts audio samples out on the serial data line, most significant bit first. Audio arrives as 32-bit words on a ready/valid stream. A word is consumed bit by bit across the channel slots. When the sample length is shorter than 32 bits, one word therefore spans more than one channel slot, and the next word is fetched only once all 32 of its bits are gone.

The bit timing comes from a clock-enable divider driven by the system clock. The divisor is a 16.8 fixed-point number of system cycles per step, and every output bit takes two steps. For a target sample rate, the divisor is therefore sysclk / (sample_rate × depth × 2) / 2. The sample depth is programmed at run time as depth minus two. Word-select changes together with the last bit of each channel slot, so it leads the next slot's first bit by one bit clock.

Dropping `enable` returns the block to the start of a left slot with all lines low. If no word is offered when one is needed, the link freezes and a sticky underrun flag rises.

Top module: `i2s_ctrl_tx`

## Requirements
- R1: After reset, with `enable` low, `sd`, `bck`, `ws`, `underrun` and `word_ready` are all 0.
- R2: Each bit takes two steps. In the first step `sd` takes the new bit and `bck` is driven low. In the second step `bck` goes high. `sd` never changes while `bck` is high.
- R3: The left slot is sent with `ws` = 0 and the right slot with `ws` = 1, alternating without a gap. `ws` takes the next slot's level together with the last bit of the current slot, always in a step where `bck` falls.
- R4: A slot carries `depth_m2` + 2 bits. The values 14, 22 and 30 give 16, 24 and 30+2 = 32 bits. Values above 30 act as 30.
- R5: Words are sent MSB first (bit 31 first) as one continuous bit stream across slots. A new word is taken only after all 32 bits of the previous one are out. `word_ready` is high only in a step that needs a new word.
- R6: Steps occur on a fractional clock enable. On average there is one step per `divisor`/256 system cycles, and a divisor below 256 gives a step every cycle. `sd`, `bck` and `ws` change only on steps.
- R7: If no word is valid when one is needed, the step stalls with `sd`, `bck` and `ws` held. `underrun` then rises and stays high while enabled. Transmission resumes once a word is offered.
- R8: While `enable` is low, the block returns to the start of a left slot: `bck`, `ws` and `sd` are low, the bit counter is reloaded, any partly sent word is dropped, and `underrun` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the link; low returns it to idle |
| depth_m2 | input | DEPTH_W | Sample length minus two |
| divisor | input | DIV_INT_W+DIV_FRAC_W | System cycles per step, fixed point |
| word_data | input | WORD_W | Audio word |
| word_valid | input | 1 | `word_data` is offered |
| word_ready | output | 1 | A word is taken this cycle if valid |
| sd | output | 1 | Serial data |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 = left |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The hardest situations to reach from the ports are a stall in the middle of the stream and a restart in the middle of a slot. In both cases the bit counter, the word shift register and the channel side must stay consistent. The stimulus starves the stream exactly at a word boundary, checks that the lines freeze, then offers more words and checks that the slot pattern carries on unbroken. It then drops `enable` part-way through a 24-bit slot, where a word straddles two slots, and checks that the next run starts cleanly in a left slot. A fractional divisor of 2.5 is used to confirm the exact long-run bit period.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   // Half of a serial bit: low half loads data, high half raises the clock
   typedef enum logic {
      STEP_LO = 1'b0,
      STEP_HI = 1'b1
   } step_e;
endpackage

// File: rtl/i2s_tx_clk_en.sv
module i2s_tx_clk_en #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [INT_W+FRAC_W-1:0] divisor,
   output logic                    tick
);
   localparam int W = INT_W + FRAC_W;

   generate
      if (FRAC_W == 0) begin : g_int
         logic [W-1:0] cnt;
         logic         hit;
         always_comb hit = (divisor <= W'(1)) || (cnt >= divisor - W'(1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else if (!run) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else begin
               tick <= hit;
               cnt  <= hit ? '0 : cnt + W'(1);
            end
         end
      end else begin : g_frac
         localparam logic [W:0] ONE = (W+1)'(1) << FRAC_W;
         logic [W:0] acc, sum, div_eff;
         logic       hit;
         always_comb begin
            div_eff = ({1'b0, divisor} < ONE) ? ONE : {1'b0, divisor};
            sum     = acc + ONE;
            hit     = (sum >= div_eff);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc  <= '0;
               tick <= 1'b0;
            end else if (!run) begin
               acc  <= '0;
               tick <= 1'b0;
            end else begin
               tick <= hit;
               acc  <= hit ? sum - div_eff : sum;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              take,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_ready,
   output logic              avail,
   output logic              nxt_bit
);
   localparam int CW = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] shreg;
   logic [CW-1:0]     left;
   logic              empty;

   always_comb begin
      empty      = (left == '0);
      word_ready = take & empty;
      avail      = !empty | word_valid;
      nxt_bit    = empty ? word_data[WORD_W-1] : shreg[WORD_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
      end else if (!run) begin
         shreg <= '0;
         left  <= '0;
      end else if (take && avail) begin
         if (empty) begin
            shreg <= word_data << 1;
            left  <= CW'(WORD_W - 1);
         end else begin
            shreg <= shreg << 1;
            left  <= left - CW'(1);
         end
      end
   end
endmodule

// File: rtl/i2s_tx_seq.sv
module i2s_tx_seq
   import i2s_tx_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int DEPTH_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [DEPTH_W-1:0] depth_m2,
   input  logic               avail,
   input  logic               nxt_bit,
   output logic               take,
   output logic               sd,
   output logic               bck,
   output logic               ws,
   output logic               underrun
);
   localparam int         BW     = $clog2(WORD_W);
   localparam logic [31:0] MAX_M2 = 32'(WORD_W - 2);

   step_e         step;
   logic [BW-1:0] cnt;
   logic [BW-1:0] reload_v;
   logic [31:0]   m2_ext;
   logic          chan;

   always_comb begin
      m2_ext   = 32'(depth_m2);
      reload_v = (m2_ext > MAX_M2) ? BW'(WORD_W - 1) : BW'(m2_ext + 32'd1);
      take     = run & tick & (step == STEP_LO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step     <= STEP_LO;
         cnt      <= '0;
         chan     <= 1'b0;
         sd       <= 1'b0;
         bck      <= 1'b0;
         ws       <= 1'b0;
         underrun <= 1'b0;
      end else if (!run) begin
         step     <= STEP_LO;
         cnt      <= reload_v;
         chan     <= 1'b0;
         sd       <= 1'b0;
         bck      <= 1'b0;
         ws       <= 1'b0;
         underrun <= 1'b0;
      end else if (tick) begin
         if (step == STEP_LO) begin
            if (avail) begin
               sd   <= nxt_bit;
               bck  <= 1'b0;
               ws   <= chan ^ (cnt == '0);
               step <= STEP_HI;
            end else begin
               underrun <= 1'b1;
            end
         end else begin
            bck  <= 1'b1;
            step <= STEP_LO;
            if (cnt == '0) begin
               cnt  <= reload_v;
               chan <= ~chan;
            end else begin
               cnt <= cnt - BW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/i2s_ctrl_tx.sv
module i2s_ctrl_tx #(
   parameter int WORD_W     = 32,
   parameter int DEPTH_W    = 5,
   parameter int DIV_INT_W  = 16,
   parameter int DIV_FRAC_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           enable,
   input  logic [DEPTH_W-1:0]             depth_m2,
   input  logic [DIV_INT_W+DIV_FRAC_W-1:0] divisor,
   input  logic [WORD_W-1:0]              word_data,
   input  logic                           word_valid,
   output logic                           word_ready,
   output logic                           sd,
   output logic                           bck,
   output logic                           ws,
   output logic                           underrun
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if ((2 ** DEPTH_W) < WORD_W - 1) begin : g_bad_depth
         $error("DEPTH_W too narrow to express WORD_W-2");
      end
      if (DIV_INT_W < 1) begin : g_bad_div
         $error("DIV_INT_W must be at least 1");
      end
   endgenerate

   logic tick;
   logic take;
   logic avail;
   logic nxt_bit;

   i2s_tx_clk_en #(
      .INT_W (DIV_INT_W),
      .FRAC_W(DIV_FRAC_W)
   ) u_clk_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (enable),
      .divisor(divisor),
      .tick   (tick)
   );

   i2s_tx_shifter #(
      .WORD_W(WORD_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable),
      .take      (take),
      .word_data (word_data),
      .word_valid(word_valid),
      .word_ready(word_ready),
      .avail     (avail),
      .nxt_bit   (nxt_bit)
   );

   i2s_tx_seq #(
      .WORD_W (WORD_W),
      .DEPTH_W(DEPTH_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (enable),
      .tick    (tick),
      .depth_m2(depth_m2),
      .avail   (avail),
      .nxt_bit (nxt_bit),
      .take    (take),
      .sd      (sd),
      .bck     (bck),
      .ws      (ws),
      .underrun(underrun)
   );
endmodule

// File: rtl/i2s_ctrl_tx_chk.sv
module i2s_ctrl_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic tick,
   input logic word_ready,
   input logic word_valid,
   input logic sd,
   input logic bck,
   input logic ws,
   input logic underrun
);
   AST_SD_MOVES_WITH_BCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sd) |-> !bck); // R2

   AST_WS_WITH_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      enable && $past(enable) && !$stable(ws) |-> $fell(bck)); // R3

   AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready |-> tick); // R5

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enable) && !$past(tick) |-> $stable(sd) && $stable(bck) && $stable(ws)); // R6

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      enable && underrun |=> underrun); // R7

   AST_UNDERRUN_ONLY_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(word_ready && !word_valid)); // R7

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !bck && !ws && !sd && !underrun); // R8
endmodule

bind i2s_ctrl_tx i2s_ctrl_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .tick      (tick),
   .word_ready(word_ready),
   .word_valid(word_valid),
   .sd        (sd),
   .bck       (bck),
   .ws        (ws),
   .underrun  (underrun)
);

// File: tb/test_i2s_ctrl_tx.sv
module test_i2s_ctrl_tx;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [4:0]  depth_m2 = 5'd14;
   logic [23:0] divisor = 24'd512;
   logic [31:0] word_data = '0;
   logic        word_valid = 1'b0;
   logic        word_ready, sd, bck, ws, underrun;

   i2s_ctrl_tx i_i2s_ctrl_tx (
      .clk(clk), .rst_n(rst_n), .enable(enable), .depth_m2(depth_m2),
      .divisor(divisor), .word_data(word_data), .word_valid(word_valid),
      .word_ready(word_ready), .sd(sd), .bck(bck), .ws(ws), .underrun(underrun)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [31:0] word_q[$];
   logic        exp_q[$];
   bit          acc_flag = 0;

   int  mon_bits = 16;
   int  mon_pos = 0;
   bit  mon_ch = 0;
   bit  prev_bck = 0;
   bit  cap_sd = 0;
   int  rise_total = 0;
   int  rise_cyc[0:255];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_word(input logic [31:0] w);
      word_q.push_back(w);
      for (int i = 31; i >= 0; i--) exp_q.push_back(w[i]);
   endtask

   task automatic mon_restart(input int bits);
      mon_bits = bits;
      mon_pos = 0;
      mon_ch = 0;
      rise_total = 0;
   endtask

   task automatic wait_drain(input string req);
      int n = 0;
      while (exp_q.size() != 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   // Feeder: note acceptance at the edge, update the offered word half a cycle later
   always @(posedge clk) if (word_valid && word_ready) acc_flag = 1;
   always @(negedge clk) begin
      if (acc_flag) begin
         if (word_q.size() != 0) void'(word_q.pop_front());
         acc_flag = 0;
      end
      word_valid = (word_q.size() != 0);
      word_data  = (word_q.size() != 0) ? word_q[0] : 32'h0;
   end

   // Monitor: scoreboard compare on every rising bit clock
   always @(negedge clk) begin
      cyc++;
      if (bck && !prev_bck) begin
         rise_cyc[rise_total % 256] = cyc;
         rise_total++;
         cap_sd = sd;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected bit", 1, 0);
         end else begin
            bit e;
            bit ews;
            e = exp_q.pop_front();
            check(sd == e, "R5 data bit", sd, e);
            ews = mon_ch ^ (mon_pos == mon_bits - 1);
            check(ws == ews, "R3 word select", ws, ews);
            mon_pos++;
            if (mon_pos == mon_bits) begin
               mon_pos = 0;
               mon_ch = ~mon_ch;
            end
         end
      end else if (bck && prev_bck) begin
         check(sd == cap_sd, "R2 sd stable while bck high", sd, cap_sd);
      end
      prev_bck = bck;
   end

   initial begin
      int n;
      while (cyc < WATCHDOG) @(negedge clk);
      check(1'b0, "watchdog", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic hb, hw, hs;
      bit   still;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check(sd == 0, "R1 sd", sd, 0);
      check(bck == 0, "R1 bck", bck, 0);
      check(ws == 0, "R1 ws", ws, 0);
      check(underrun == 0, "R1 underrun", underrun, 0);
      check(word_ready == 0, "R1 word_ready", word_ready, 0);

      // 16-bit slots, divisor 2.0 (R4, R5)
      depth_m2 = 5'd14; divisor = 24'd512;
      mon_restart(16);
      push_word(32'hA5C3_0F96); push_word(32'h1234_5678);
      push_word(32'hFFFF_0000); push_word(32'h8001_7FFE);
      repeat (3) @(negedge clk);
      enable = 1'b1;
      wait_drain("R5 16-bit stream drained");
      check(rise_total == 128, "R4 16-bit bit count", rise_total, 128);

      // R7 starvation: hold lines and flag underrun
      repeat (60) @(negedge clk);
      check(underrun == 1, "R7 underrun raised", underrun, 1);
      hb = bck; hw = ws; hs = sd; still = 1;
      repeat (40) begin
         @(negedge clk);
         if (bck != hb || ws != hw || sd != hs) still = 0;
      end
      check(still, "R7 lines held during stall", still, 1);
      check(rise_total == 128, "R7 no bits while starved", rise_total, 128);

      // R7 resume keeps slot pattern and flag stays
      push_word(32'h0F0F_F0F0); push_word(32'hDEAD_BEEF);
      wait_drain("R7 resume drained");
      check(underrun == 1, "R7 underrun sticky", underrun, 1);

      // R8 disable returns to idle
      @(negedge clk); enable = 1'b0;
      repeat (3) @(negedge clk);
      check(bck == 0 && ws == 0 && sd == 0, "R8 lines low when off", {bck, ws, sd}, 0);
      check(underrun == 0, "R8 underrun cleared", underrun, 0);

      // 24-bit slots, divisor 3.0, drop enable mid-slot (R8, R4)
      depth_m2 = 5'd22; divisor = 24'd768;
      mon_restart(24);
      push_word(32'hC0FF_EE11); push_word(32'h2233_4455); push_word(32'h6677_8899);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      while (rise_total < 10) @(negedge clk);
      enable = 1'b0;
      repeat (4) @(negedge clk);
      word_q.delete(); exp_q.delete();
      repeat (2) @(negedge clk);
      check(bck == 0 && ws == 0, "R8 mid-slot stop idle", {bck, ws}, 0);
      mon_restart(24);
      push_word(32'h0123_4567); push_word(32'h89AB_CDEF); push_word(32'h5A5A_A5A5);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      wait_drain("R8 restart from left slot");
      check(rise_total == 96, "R4 24-bit bit count", rise_total, 96);
      @(negedge clk); enable = 1'b0;
      repeat (3) @(negedge clk);

      // depth 31 clamps to 32-bit, fractional divisor 2.5 (R4, R6)
      depth_m2 = 5'd31; divisor = 24'd640;
      mon_restart(32);
      push_word(32'hF00D_1234); push_word(32'h0000_FFFF);
      push_word(32'h7E7E_8181); push_word(32'h3C3C_C3C3);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      wait_drain("R4 32-bit stream drained");
      check(rise_total == 128, "R4 clamped depth bit count", rise_total, 128);
      check(rise_cyc[21] - rise_cyc[1] == 100, "R6 fractional period", rise_cyc[21] - rise_cyc[1], 100);
      @(negedge clk); enable = 1'b0;
      repeat (3) @(negedge clk);

      // divisor below one: step every cycle (R6)
      depth_m2 = 5'd14; divisor = 24'd128;
      mon_restart(16);
      push_word(32'h9696_6969); push_word(32'h1357_9BDF);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      wait_drain("R6 fast stream drained");
      check(rise_cyc[11] - rise_cyc[1] == 20, "R6 minimum divisor period", rise_cyc[11] - rise_cyc[1], 20);
      @(negedge clk); enable = 1'b0;
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule